// File: doc/BRIEF.md
# Misaligned access splitter for a 32-bit bus

This block sits between a simple requester and a 32-bit pipelined bus master port. The requester presents one access at a time: an address, a size (byte, halfword or word), a direction flag and write data. If the access meets natural alignment, it leaves the block as a single bus transfer with the same address and size. If it does not, the block breaks it into a short, fixed sequence of naturally aligned transfers. So every address/size pair that reaches the bus is aligned, and no error is raised for misalignment.

For writes, each transfer carries the bytes it covers, moved onto the byte lanes its address selects. For reads, the bytes returned on those lanes are moved back into request order and merged. The requester receives one completion pulse with the merged value after the last transfer's data phase is accepted. Byte order is little-endian throughout.

The controller has four states. `S_IDLE` waits for a request. `S_ADDR` drives one address phase. `S_DATA` holds the data phase until the bus is ready. `S_FINISH` raises the completion pulse. The transitions are:
- Accepting a request moves `S_IDLE` to `S_ADDR`.
- `S_ADDR` always moves to `S_DATA`.
- While the bus is waiting, `S_DATA` stays in `S_DATA`.
- On an accepted data phase, `S_DATA` returns to `S_ADDR` if transfers remain, and goes to `S_FINISH` after the last one.
- `S_FINISH` always returns to `S_IDLE`.

Top module: `misalign_bridge`

## Requirements
- R1: Size codes are 00 byte, 01 halfword, 10 word; 11 is treated as a word. A request is misaligned when its low log2(size) address bits are not all zero. An aligned request of any size is issued as exactly one transfer at the request address with the request size.
- R2: A word request with addr[1:0]=10 is issued as two halfword transfers, first at A and then at A+2.
- R3: A word request with addr[1:0]=01 or 11 is issued as a byte at A, then a halfword at A+1, then a byte at A+3.
- R4: A halfword request at an odd address is issued as two byte transfers, first at A and then at A+1.
- R5: Every transfer with `bus_trans` high has an aligned address for its `bus_size`.
- R6: In a write data phase, lanes addr[1:0] through addr[1:0]+size-1 of `bus_wdata` carry the request bytes that transfer covers, lowest address first starting at request bits [7:0]. All other lanes are zero.
- R7: The read result holds the byte at the lowest address in bits [7:0], then the following bytes in order. Bytes above the request size are zero. Bus lanes outside the active lanes are ignored. A write completes with a zero result.
- R8: `req_idle` is high only in `S_IDLE`. `req_valid` is ignored while busy. `done_pulse` is high for exactly one cycle, one cycle after the last data phase is accepted.
- R9: An address phase lasts one cycle. The next address is not presented until the current data phase is accepted (`bus_ready` high). A low `bus_ready` stretches the data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; taken when idle |
| req_addr | input | ADDR_W | Request byte address |
| req_size | input | 2 | Request size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Request write data, little-endian |
| req_idle | output | 1 | Block can take a request this cycle |
| done_pulse | output | 1 | One-cycle completion |
| done_rdata | output | 32 | Merged read value, valid with done_pulse |
| bus_trans | output | 1 | Address phase valid |
| bus_addr | output | ADDR_W | Transfer address |
| bus_size | output | 2 | Transfer size code |
| bus_write | output | 1 | Transfer direction |
| bus_wdata | output | 32 | Write data during the data phase |
| bus_rdata | input | 32 | Read data, taken when bus_ready is high in a data phase |
| bus_ready | input | 1 | Data phase accepted |

## Verification
The request is taken at clock edge 0. Each transfer's address phase then appears for one cycle. It is followed by a data phase of 1 + w cycles, where w is the number of wait cycles the bus model inserts. The completion pulse is therefore due n·(2+w)+1 cycles after acceptance, for n transfers. The bench counts falling edges from the accepting edge and compares that count with this formula. All sampling happens on falling edges: the bus model checks each address phase when it appears and each write data phase at the falling edge where it grants ready. Expected transfers come from a greedy aligned decomposition written separately in the bench, and expected read values come from the bench's own byte-memory model.

// File: rtl/misalign_pkg.sv
package misalign_pkg;
    localparam int BUS_BYTES   = 4;
    localparam int BUS_W       = 8 * BUS_BYTES;
    localparam int PIECE_SLOTS = 4;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_ADDR   = 2'd1,
        S_DATA   = 2'd2,
        S_FINISH = 2'd3
    } state_e;

    typedef struct packed {
        logic [1:0] rel;   // byte offset of the piece inside the request
        logic [1:0] sz;    // log2 of the piece size
    } piece_t;

    function automatic logic [BUS_W-1:0] byte_mask(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: byte_mask = 32'h0000_00FF;
            SZ_HALF: byte_mask = 32'h0000_FFFF;
            default: byte_mask = 32'hFFFF_FFFF;
        endcase
    endfunction
endpackage

// File: rtl/split_plan.sv
module split_plan
    import misalign_pkg::*;
(
    input  logic [1:0]                   lsb,
    input  logic [1:0]                   size,
    output logic [1:0]                   count,
    output piece_t [PIECE_SLOTS-1:0]     pieces
);
    logic [1:0] size_eff;

    assign size_eff = (size == 2'b11) ? SZ_WORD : size;

    always_comb begin
        count  = 2'd1;
        pieces = '0;
        pieces[0].sz = size_eff;
        if (size_eff == SZ_HALF && lsb[0]) begin
            count     = 2'd2;
            pieces[0] = '{rel: 2'd0, sz: SZ_BYTE};
            pieces[1] = '{rel: 2'd1, sz: SZ_BYTE};
        end else if (size_eff == SZ_WORD && lsb == 2'b10) begin
            count     = 2'd2;
            pieces[0] = '{rel: 2'd0, sz: SZ_HALF};
            pieces[1] = '{rel: 2'd2, sz: SZ_HALF};
        end else if (size_eff == SZ_WORD && lsb[0]) begin
            count     = 2'd3;
            pieces[0] = '{rel: 2'd0, sz: SZ_BYTE};
            pieces[1] = '{rel: 2'd1, sz: SZ_HALF};
            pieces[2] = '{rel: 2'd3, sz: SZ_BYTE};
        end
    end
endmodule

// File: rtl/lane_steer.sv
module lane_steer
    import misalign_pkg::*;
(
    input  logic [BUS_W-1:0] req_wdata,
    input  logic [BUS_W-1:0] bus_rdata,
    input  logic [1:0]       rel,
    input  logic [1:0]       lane,
    input  logic [1:0]       sz,
    output logic [BUS_W-1:0] lane_wdata,
    output logic [BUS_W-1:0] read_part
);
    logic [BUS_W-1:0] mask;
    logic [4:0]       rel_sh;
    logic [4:0]       lane_sh;

    assign mask    = byte_mask(sz);
    assign rel_sh  = {rel, 3'b000};
    assign lane_sh = {lane, 3'b000};

    assign lane_wdata = ((req_wdata >> rel_sh) & mask) << lane_sh;
    assign read_part  = ((bus_rdata >> lane_sh) & mask) << rel_sh;
endmodule

// File: rtl/misalign_bridge.sv
module misalign_bridge
    import misalign_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic [BUS_W-1:0]  req_wdata,
    output logic              req_idle,
    output logic              done_pulse,
    output logic [BUS_W-1:0]  done_rdata,
    output logic              bus_trans,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic              bus_write,
    output logic [BUS_W-1:0]  bus_wdata,
    input  logic [BUS_W-1:0]  bus_rdata,
    input  logic              bus_ready
);
    state_e                   state, state_nx;
    logic [ADDR_W-1:0]        base_q;
    logic                     write_q;
    logic [BUS_W-1:0]         wdata_q;
    logic [1:0]               count_q;
    piece_t [PIECE_SLOTS-1:0] pieces_q;
    logic [1:0]               idx_q;
    logic [BUS_W-1:0]         acc_q;

    logic [1:0]               plan_count;
    piece_t [PIECE_SLOTS-1:0] plan_pieces;
    piece_t                   cur;
    logic [ADDR_W-1:0]        cur_addr;
    logic [BUS_W-1:0]         steer_w;
    logic [BUS_W-1:0]         read_part;
    logic                     accept;
    logic                     beat_done;
    logic                     last_piece;

    split_plan u_plan (
        .lsb    (req_addr[1:0]),
        .size   (req_size),
        .count  (plan_count),
        .pieces (plan_pieces)
    );

    assign cur      = pieces_q[idx_q];
    assign cur_addr = base_q + {{(ADDR_W-2){1'b0}}, cur.rel};

    lane_steer u_steer (
        .req_wdata  (wdata_q),
        .bus_rdata  (bus_rdata),
        .rel        (cur.rel),
        .lane       (cur_addr[1:0]),
        .sz         (cur.sz),
        .lane_wdata (steer_w),
        .read_part  (read_part)
    );

    assign accept     = (state == S_IDLE) && req_valid;
    assign beat_done  = (state == S_DATA) && bus_ready;
    assign last_piece = (idx_q == count_q - 2'd1);

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (req_valid) state_nx = S_ADDR;
            S_ADDR:   state_nx = S_DATA;
            S_DATA:   if (bus_ready) state_nx = last_piece ? S_FINISH : S_ADDR;
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // request context and read accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q   <= '0;
            write_q  <= 1'b0;
            wdata_q  <= '0;
            count_q  <= 2'd1;
            pieces_q <= '0;
            idx_q    <= 2'd0;
            acc_q    <= '0;
        end else if (accept) begin
            base_q   <= req_addr;
            write_q  <= req_write;
            wdata_q  <= req_wdata;
            count_q  <= plan_count;
            pieces_q <= plan_pieces;
            idx_q    <= 2'd0;
            acc_q    <= '0;
        end else if (beat_done) begin
            idx_q <= idx_q + 2'd1;
            if (!write_q) acc_q <= acc_q | read_part;
        end
    end

    // outputs
    always_comb begin
        req_idle   = (state == S_IDLE);
        done_pulse = (state == S_FINISH);
        done_rdata = acc_q;
        bus_trans  = (state == S_ADDR);
        bus_addr   = cur_addr;
        bus_size   = cur.sz;
        bus_write  = write_q;
        bus_wdata  = (state == S_DATA && write_q) ? steer_w : '0;
    end

    // R5
    aligned_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_trans |-> (bus_size == SZ_BYTE)
                   || (bus_size == SZ_HALF && !bus_addr[0])
                   || (bus_size == SZ_WORD && bus_addr[1:0] == 2'b00));

    // R9
    addr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_trans |=> !bus_trans);

    // R9
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && !bus_ready) |=> (!bus_trans && $stable(bus_addr)));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> (!done_pulse && req_idle));

    // R8
    busy_no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_trans || done_pulse) |-> !req_idle);

    // R6
    byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && bus_size == SZ_BYTE)
            |-> ((bus_wdata & ~(32'hFF << {bus_addr[1:0], 3'b000})) == '0));
endmodule

// File: tb/misalign_bridge_bench.sv
module misalign_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        req_idle, done_pulse, bus_trans, bus_write;
    logic [31:0] done_rdata, bus_addr, bus_wdata;
    logic [1:0]  bus_size;
    logic [31:0] bus_rdata = '0;
    logic        bus_ready = 1'b1;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int since_accept = 0;
    int done_count = 0;
    int wait_cfg = 0;

    logic [7:0]  mem [32];
    logic [7:0]  ref_mem [32];

    logic [31:0] q_addr [$];
    logic [1:0]  q_size [$];
    logic        q_wr [$];
    logic [31:0] q_wd [$];
    logic [31:0] r_data [$];
    int          r_lat [$];

    logic        pend = 1'b0;
    logic [31:0] pend_addr;
    logic [1:0]  pend_size;
    logic        pend_wr;
    logic [31:0] pend_wd;
    int          waits_left = 0;

    misalign_bridge u_misalign_bridge (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .req_idle(req_idle), .done_pulse(done_pulse), .done_rdata(done_rdata),
        .bus_trans(bus_trans), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", cycles, 20000);
            finish_run();
        end
    end

    // bus model and scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            since_accept++;
            if (pend) begin
                check(!bus_trans, "R9 address during data phase", {31'b0, bus_trans}, 32'h0);
                if (waits_left > 0) begin
                    bus_ready = 1'b0;
                    waits_left--;
                end else begin
                    int b;
                    b = int'(pend_addr) & 28;
                    bus_ready = 1'b1;
                    bus_rdata = {mem[b+3], mem[b+2], mem[b+1], mem[b]};
                    if (pend_wr) begin
                        check(bus_wdata == pend_wd, "R6 write lanes", bus_wdata, pend_wd);
                        for (int l = 0; l < 4; l++)
                            if (l >= int'(pend_addr[1:0]) && l < int'(pend_addr[1:0]) + (1 << pend_size))
                                mem[b+l] = bus_wdata[8*l +: 8];
                    end
                    pend = 1'b0;
                end
            end else if (bus_trans) begin
                if (q_addr.size() == 0) begin
                    check(1'b0, "R1 unexpected transfer", bus_addr, 32'hFFFF_FFFF);
                end else begin
                    logic [31:0] ea;
                    logic [1:0]  es;
                    logic        ew;
                    ea = q_addr.pop_front();
                    es = q_size.pop_front();
                    ew = q_wr.pop_front();
                    pend_wd = q_wd.pop_front();
                    check(bus_addr == ea && bus_size == es && bus_write == ew,
                          "R1 R2 R3 R4 transfer address/size", {bus_addr[29:0], bus_size},
                          {ea[29:0], es});
                end
                pend = 1'b1;
                pend_addr = bus_addr;
                pend_size = bus_size;
                pend_wr = bus_write;
                waits_left = wait_cfg;
            end
            if (done_pulse) begin
                logic [31:0] ed;
                int el;
                ed = r_data.pop_front();
                el = r_lat.pop_front();
                check(done_rdata == ed, "R7 merged result", done_rdata, ed);
                check(since_accept == el && !req_idle, "R8 completion timing",
                      since_accept, el);
                done_count++;
            end
        end
    end

    // driver: greedy aligned decomposition as the reference
    task automatic do_req(input logic wr, input logic [31:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, input bit noise);
        int cur, rem, k, n, prev;
        logic [31:0] exp_rd;
        cur = int'(a); rem = 1 << sz; k = 0; n = 0; exp_rd = '0;
        while (rem > 0) begin
            int s;
            logic [31:0] ew;
            s = (cur % 4 == 0 && rem >= 4) ? 4 : (cur % 2 == 0 && rem >= 2) ? 2 : 1;
            ew = '0;
            for (int l = 0; l < 4; l++)
                if (wr && l >= cur % 4 && l < cur % 4 + s)
                    ew[8*l +: 8] = wd[8*(k + l - cur % 4) +: 8];
            q_addr.push_back(32'(cur));
            q_size.push_back(s == 4 ? 2'b10 : s == 2 ? 2'b01 : 2'b00);
            q_wr.push_back(wr);
            q_wd.push_back(ew);
            cur += s; rem -= s; k += s; n++;
        end
        for (int j = 0; j < (1 << sz); j++) begin
            if (wr) ref_mem[(int'(a) + j) & 31] = wd[8*j +: 8];
            else    exp_rd[8*j +: 8] = ref_mem[(int'(a) + j) & 31];
        end
        r_data.push_back(exp_rd);
        r_lat.push_back(n * (2 + wait_cfg) + 1);
        prev = done_count;
        @(negedge clk);
        while (!req_idle) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; req_wdata = wd;
        @(posedge clk);
        since_accept = 0;
        @(negedge clk);
        if (noise) begin
            req_addr = 32'h1; req_size = 2'b10; req_write = 1'b1; req_wdata = 32'hDEAD_BEEF;
            @(negedge clk);
        end
        req_valid = 1'b0;
        wait (done_count == prev + 1);
        @(negedge clk);
        check(req_idle && !bus_trans, "R8 idle after completion", {31'b0, req_idle}, 32'h1);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            mem[i] = 8'(i * 8'h1D) ^ 8'h5A;
            ref_mem[i] = mem[i];
        end
        #1;
        check(req_idle && !bus_trans && !done_pulse, "R8 reset state",
              {29'b0, req_idle, bus_trans, done_pulse}, 32'h4);
        #22 rst_n = 1'b1;

        wait_cfg = 0;
        do_req(1'b0, 32'h05, 2'b00, '0, 0);              // R1 aligned byte
        do_req(1'b0, 32'h06, 2'b01, '0, 0);              // R1 aligned half
        do_req(1'b0, 32'h08, 2'b10, '0, 0);              // R1 aligned word
        do_req(1'b0, 32'h0A, 2'b10, '0, 0);              // R2 word at 10
        wait_cfg = 1;
        do_req(1'b0, 32'h0D, 2'b10, '0, 0);              // R3 word at 01, R9 waits
        wait_cfg = 2;
        do_req(1'b0, 32'h0F, 2'b10, '0, 0);              // R3 word at 11 across words
        wait_cfg = 0;
        do_req(1'b0, 32'h13, 2'b01, '0, 0);              // R4 odd half
        do_req(1'b1, 32'h15, 2'b10, 32'hA1B2_C3D4, 1);   // R3 R6 write, R8 noise ignored
        do_req(1'b0, 32'h14, 2'b10, '0, 0);              // R7 readback
        do_req(1'b0, 32'h18, 2'b10, '0, 0);              // R7 readback
        do_req(1'b0, 32'h15, 2'b10, '0, 0);              // R3 R7 readback
        wait_cfg = 1;
        do_req(1'b1, 32'h1B, 2'b01, 32'h0000_9E7F, 0);   // R4 R6 odd half write
        do_req(1'b1, 32'h02, 2'b00, 32'h0000_0066, 0);   // R1 R6 byte write
        do_req(1'b1, 32'h06, 2'b10, 32'h1122_3344, 1);   // R2 R6 split halves write
        wait_cfg = 0;
        do_req(1'b0, 32'h00, 2'b10, '0, 0);              // R7 readback
        do_req(1'b0, 32'h04, 2'b10, '0, 0);              // R7
        do_req(1'b0, 32'h1A, 2'b10, '0, 0);              // R2 R7
        do_req(1'b0, 32'h1B, 2'b01, '0, 0);              // R4 R7
        repeat (3) @(negedge clk);
        check(q_addr.size() == 0, "R1 leftover transfers", q_addr.size(), 32'h0);
        finish_run();
    end
endmodule